// File: doc/BRIEF.md
# System Control Register File

This block is a 4 KiB window of 32-bit control and status words on a simple bus with single-cycle access. The address is a 12-bit byte offset, and the word is selected by that offset divided by four. Only the lower 512 words hold storage. Four of those words come out of reset holding fixed identification and configuration values. Three of them also report two status bits as permanently set whenever they are read, and this does not change the stored contents.

One word sits above the backed storage and acts as a power-control doorbell. Writing certain codes to it raises a one-cycle system-reset request or shutdown request toward the chip's power sequencer. Any access above the backed range raises a one-cycle bad-access flag. This includes the doorbell write, which still triggers its request. Software uses the block for board identification words, scratch configuration, and a way to restart or halt the system.

Top module: `sysctl_regfile`

## Requirements
- R1: After reset, a read of byte offset 0x100 returns 0x35F20121, 0x104 returns 0x00000002, 0x108 returns 0x35F30121 and 0x10C returns 0x35F40121. This reflects stored reset values 0x05F20121, 0x00000002, 0x05F30121 and 0x05F40121 at word indices 0x40 to 0x43.
- R2: All other backed words read as zero after reset, and `rdata`, `reset_req`, `shutdown_req` and `bad_access` are low.
- R3: A write with `wr_en` high stores all 32 bits of `wdata` at word index `addr[11:2]` when that index is below 0x200. A read with `rd_en` high presents that word on `rdata` one clock later, and `rdata` holds its value while no read is made.
- R4: `addr[1:0]` take no part in word selection.
- R5: Reads of byte offsets 0x100, 0x108 and 0x10C return the stored word OR 0x30000000, which sets bits 29 and 28. Offset 0x104 and every other word return the stored word unchanged.
- R6: A write to byte offset 0xF00 with data 1 or 2 pulses `reset_req` high for one cycle, in the cycle after the write.
- R7: A write to 0xF00 with data 3 pulses `shutdown_req` for one cycle, in the cycle after the write. Any other data raises neither request. Reads of 0xF00 and writes to any other offset raise neither request. The two requests are never high together.
- R8: A write to word index 0x200 or above stores nothing and pulses `bad_access` for one cycle in the next cycle. This includes the power-control write at 0xF00.
- R9: A read from word index 0x200 or above returns zero on `rdata` and pulses `bad_access` for one cycle in the next cycle.
- R10: A read and a write to the same word in the same cycle return the value held before the write. A later read returns the new value.
- R11: Accesses inside the backed range, and cycles with no strobe, leave `bad_access` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 12 | Byte offset within the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| reset_req | output | 1 | One-cycle system-reset request |
| shutdown_req | output | 1 | One-cycle shutdown request |
| bad_access | output | 1 | One-cycle flag for an access above the backed range |

## Verification
The bench targets four corner cases:

- **Doorbell write.** This write both fires a request and flags a bad access. A design that checked the range first would lose the request. A design that skipped the range check for the doorbell would never raise the flag.
- **Out-of-range writes.** These are followed by reads of word 0. A decoder that drops the top address bit would alias the write into storage and corrupt that word.
- **Forced status bits.** These are checked on a word loaded with zero, on its unforced neighbour at 0x104, and with misaligned low address bits. A wrong mask, or forcing at 0x104, shows up directly on the read data.
- **Same-cycle read and write.** A forwarding or write-first implementation would return the new value where the old one is expected.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int ADDR_W       = 12;
    localparam int DATA_W       = 32;
    localparam int BACKED_WORDS = 512;
    localparam int IDX_W        = ADDR_W - 2;
    localparam int SLOT_W       = $clog2(BACKED_WORDS);

    localparam logic [IDX_W-1:0]  PWR_IDX    = IDX_W'(12'hF00 >> 2);
    localparam logic [DATA_W-1:0] FORCE_MASK = 32'h3000_0000;

    typedef enum logic [1:0] {
        PWR_NONE     = 2'd0,
        PWR_RESET    = 2'd1,
        PWR_SHUTDOWN = 2'd2
    } pwr_cmd_e;

    typedef struct packed {
        logic              in_range;
        logic              pwr_hit;
        logic              force_hit;
        logic [SLOT_W-1:0] slot;
    } dec_t;

    function automatic logic [DATA_W-1:0] reset_word(input logic [SLOT_W-1:0] slot);
        case (slot)
            SLOT_W'(9'h040): return 32'h05F2_0121;
            SLOT_W'(9'h041): return 32'h0000_0002;
            SLOT_W'(9'h042): return 32'h05F3_0121;
            SLOT_W'(9'h043): return 32'h05F4_0121;
            default:         return '0;
        endcase
    endfunction

    function automatic logic is_forced(input logic [IDX_W-1:0] idx);
        return (idx == IDX_W'(10'h040)) || (idx == IDX_W'(10'h042)) ||
               (idx == IDX_W'(10'h043));
    endfunction

    function automatic pwr_cmd_e pwr_code(input logic [DATA_W-1:0] d);
        if (d == DATA_W'(1) || d == DATA_W'(2)) return PWR_RESET;
        if (d == DATA_W'(3))                    return PWR_SHUTDOWN;
        return PWR_NONE;
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    logic [IDX_W-1:0] idx;
    logic [1:0]       unused_byte_lane;

    assign idx              = addr[ADDR_W-1:2];
    assign unused_byte_lane = addr[1:0];

    always_comb begin
        dec           = '0;
        dec.in_range  = (idx < IDX_W'(BACKED_WORDS));
        dec.pwr_hit   = (idx == PWR_IDX);
        dec.force_hit = is_forced(idx);
        dec.slot      = idx[SLOT_W-1:0];
    end
endmodule

// File: rtl/sysctl_store.sv
module sysctl_store
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SLOT_W-1:0] slot,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rword
);
    logic [DATA_W-1:0] mem [BACKED_WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < BACKED_WORDS; i++) begin
                mem[i] <= reset_word(SLOT_W'(i));
            end
        end else if (we) begin
            mem[slot] <= wdata;
        end
    end

    assign rword = mem[slot];
endmodule

// File: rtl/sysctl_power.sv
module sysctl_power
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              pwr_hit,
    input  logic [DATA_W-1:0] wdata,
    output logic              reset_req,
    output logic              shutdown_req
);
    pwr_cmd_e cmd;

    always_comb begin
        cmd = PWR_NONE;
        if (wr_en && pwr_hit) cmd = pwr_code(wdata);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reset_req    <= 1'b0;
            shutdown_req <= 1'b0;
        end else begin
            reset_req    <= (cmd == PWR_RESET);
            shutdown_req <= (cmd == PWR_SHUTDOWN);
        end
    end

    AST_PWR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(reset_req && shutdown_req)); // R7
    AST_RESET_CAUSE: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> $past(wr_en && pwr_hit)); // R6
    AST_SHUT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        shutdown_req |-> $past(wr_en && pwr_hit && wdata == DATA_W'(3))); // R7
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              reset_req,
    output logic              shutdown_req,
    output logic              bad_access
);
    dec_t              dec;
    logic [DATA_W-1:0] rword;
    logic [DATA_W-1:0] rview;

    sysctl_decode u_decode (
        .addr (addr),
        .dec  (dec)
    );

    sysctl_store u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en && dec.in_range),
        .slot  (dec.slot),
        .wdata (wdata),
        .rword (rword)
    );

    sysctl_power u_power (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .pwr_hit      (dec.pwr_hit),
        .wdata        (wdata),
        .reset_req    (reset_req),
        .shutdown_req (shutdown_req)
    );

    always_comb begin
        rview = '0;
        if (dec.in_range) begin
            rview = rword | (dec.force_hit ? FORCE_MASK : '0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata      <= '0;
            bad_access <= 1'b0;
        end else begin
            if (rd_en) rdata <= rview;
            bad_access <= (rd_en || wr_en) && !dec.in_range;
        end
    end

    AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_en && !dec.in_range) && !$past(rst)) |-> (rdata == '0)); // R9
    AST_FORCE_BITS: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_en && dec.in_range && dec.force_hit) && !$past(rst))
        |-> (rdata[29:28] == 2'b11)); // R5
    AST_BAD_CAUSE: assert property (@(posedge clk) disable iff (rst)
        bad_access |-> $past(rd_en || wr_en)); // R11
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rd_en) && !$past(rst)) |-> $stable(rdata)); // R3
endmodule

// File: tb/sysctl_regfile_bench.sv
`timescale 1ns/100ps
module sysctl_regfile_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        reset_req, shutdown_req, bad_access;
    int          checks = 0;
    int          errors = 0;
    logic        done = 1'b0;

    always #2.5 clk = ~clk;

    sysctl_regfile u_sysctl_regfile (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .reset_req(reset_req),
        .shutdown_req(shutdown_req), .bad_access(bad_access)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic r, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic check_flags(input string req, input logic rr, input logic sr, input logic ba);
        check({req, " reset_req"},    {31'd0, reset_req},    {31'd0, rr});
        check({req, " shutdown_req"}, {31'd0, shutdown_req}, {31'd0, sr});
        check({req, " bad_access"},   {31'd0, bad_access},   {31'd0, ba});
    endtask

    task automatic t_reset_state;
        check_flags("R2 after reset", 1'b0, 1'b0, 1'b0);
        check("R2 rdata after reset", rdata, 32'h0);
        access(0, 1, 12'h100, 0); check("R1 word 0x100", rdata, 32'h35F2_0121);
        access(0, 1, 12'h104, 0); check("R1 word 0x104", rdata, 32'h0000_0002);
        access(0, 1, 12'h108, 0); check("R1 word 0x108", rdata, 32'h35F3_0121);
        access(0, 1, 12'h10C, 0); check("R1 word 0x10C", rdata, 32'h35F4_0121);
        access(0, 1, 12'h000, 0); check("R2 word 0x000", rdata, 32'h0);
        access(0, 1, 12'h7FC, 0); check("R2 word 0x7FC", rdata, 32'h0);
        check_flags("R11 in-range read", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_store;
        access(1, 0, 12'h000, 32'hDEAD_BEEF);
        check_flags("R11 in-range write", 1'b0, 1'b0, 1'b0);
        access(1, 0, 12'h7FC, 32'h1234_5678);
        access(0, 1, 12'h000, 0); check("R3 word 0x000", rdata, 32'hDEAD_BEEF);
        access(0, 1, 12'h7FC, 0); check("R3 word 0x7FC", rdata, 32'h1234_5678);
        repeat (3) @(negedge clk);
        check("R3 rdata holds", rdata, 32'h1234_5678);
        check_flags("R11 idle", 1'b0, 1'b0, 1'b0);
        access(1, 0, 12'h013, 32'h0000_A5A5);
        access(0, 1, 12'h010, 0); check("R4 low bits ignored on write", rdata, 32'h0000_A5A5);
        access(0, 1, 12'h012, 0); check("R4 low bits ignored on read", rdata, 32'h0000_A5A5);
    endtask

    task automatic t_force;
        access(1, 0, 12'h100, 32'h0);
        access(0, 1, 12'h100, 0); check("R5 0x100 forced", rdata, 32'h3000_0000);
        access(1, 0, 12'h104, 32'h0);
        access(0, 1, 12'h104, 0); check("R5 0x104 not forced", rdata, 32'h0);
        access(1, 0, 12'h108, 32'h0F00_0001);
        access(0, 1, 12'h108, 0); check("R5 0x108 forced", rdata, 32'h3F00_0001);
        access(0, 1, 12'h10D, 0); check("R5 0x10C forced via misaligned addr", rdata, 32'h35F4_0121);
        access(1, 0, 12'h110, 32'h0);
        access(0, 1, 12'h110, 0); check("R5 0x110 not forced", rdata, 32'h0);
    endtask

    task automatic t_power;
        access(1, 0, 12'hF00, 32'd1); check_flags("R6 data 1", 1'b1, 1'b0, 1'b1);
        @(negedge clk); check_flags("R6 pulse ends", 1'b0, 1'b0, 1'b0);
        access(1, 0, 12'hF00, 32'd2); check_flags("R6 data 2", 1'b1, 1'b0, 1'b1);
        access(1, 0, 12'hF00, 32'd3); check_flags("R7 data 3", 1'b0, 1'b1, 1'b1);
        @(negedge clk); check_flags("R7 pulse ends", 1'b0, 1'b0, 1'b0);
        access(1, 0, 12'hF00, 32'd0);         check_flags("R7 data 0", 1'b0, 1'b0, 1'b1);
        access(1, 0, 12'hF00, 32'd4);         check_flags("R7 data 4", 1'b0, 1'b0, 1'b1);
        access(1, 0, 12'hF00, 32'h0000_0101); check_flags("R7 data 0x101", 1'b0, 1'b0, 1'b1);
        access(1, 0, 12'hF04, 32'd1);         check_flags("R7 other offset", 1'b0, 1'b0, 1'b1);
        access(1, 0, 12'h040, 32'd3);         check_flags("R7 in-range offset", 1'b0, 1'b0, 1'b0);
        access(0, 1, 12'hF00, 0);             check_flags("R7 read of doorbell", 1'b0, 1'b0, 1'b1);
        check("R9 doorbell read data", rdata, 32'h0);
    endtask

    task automatic t_out_of_range;
        access(1, 0, 12'h800, 32'h1111_1111);
        check_flags("R8 write 0x800", 1'b0, 1'b0, 1'b1);
        access(1, 0, 12'hFFC, 32'h2222_2222);
        access(0, 1, 12'h000, 0); check("R8 no alias into word 0", rdata, 32'hDEAD_BEEF);
        access(0, 1, 12'h7FC, 0); check("R8 no alias into word 0x1FF", rdata, 32'h1234_5678);
        access(0, 1, 12'h800, 0); check("R9 read 0x800", rdata, 32'h0);
        check_flags("R9 read 0x800", 1'b0, 1'b0, 1'b1);
        @(negedge clk); check_flags("R9 bad pulse ends", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_same_cycle;
        access(1, 1, 12'h000, 32'hCAFE_F00D); check("R10 old value", rdata, 32'hDEAD_BEEF);
        access(0, 1, 12'h000, 0);             check("R10 new value", rdata, 32'hCAFE_F00D);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_store();
        t_force();
        t_power();
        t_out_of_range();
        t_same_cycle();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule